// File: doc/BRIEF.md
# Bridge Configuration Cycle Router

This block sits on the downstream side of a bus bridge. It looks at every configuration request that arrives from upstream and decides what to do with it. Each request carries a 32-bit configuration address, a read/write flag and a valid strobe. The block holds two programmable bus numbers: the lowest bus behind the bridge (the "near" bus) and the highest bus behind it (the "far" bus).

A request with the routed cycle type is claimed only when its bus field lies within the inclusive near-to-far range. If the bus field names the near bus itself, the request is rewritten as a local cycle. The rewritten address keeps the function and register fields and has a zero type code. One bit of a 32-bit device-select vector, picked by the device field, is raised as the target's chip select. A claimed request for a bus further down is passed on unchanged. Every other request is left unclaimed.

All results appear one clock after the request. Software loads the two bus numbers through a write strobe, and a load takes effect for requests from the next cycle on.

Top module: `cfgx_router`

## Requirements
- R1: Outputs are registered. `out_valid` equals `req_valid` from one cycle earlier, and `out_write` equals the earlier `req_write` when that request was valid and 0 otherwise. A cycle with no request gives all-zero claim, convert, address and select outputs.
- R2: The type code is address bits [1:0]. Only code 01 (routed cycle) can be claimed. Codes 00, 10 and 11 are never claimed.
- R3: A type-01 request is claimed exactly when near <= bus <= far, where bus is address bits [23:16] and both bounds are inclusive.
- R4: A claimed request with bus equal to near is converted. `out_conv` is 1. `out_addr[10:2]` equals the request's bits [10:2] (function [10:8], register [7:2]). `out_addr[1:0]` is 00 and `out_addr[31:11]` is 0.
- R5: On conversion exactly one bit of `out_sel` is 1: the bit whose index is the device field, address bits [15:11]. Otherwise `out_sel` is all zero.
- R6: A claimed request with near < bus <= far is forwarded. `out_addr` equals the request address bit for bit, and `out_conv` is 0.
- R7: An unclaimed request gives `out_claim` 0, `out_conv` 0, `out_addr` 0 and `out_sel` 0.
- R8: Reset sets near and far to 0 and clears all outputs. While far is 0, no request is claimed.
- R9: A bus-number load with `rng_we` takes effect from the next cycle. A request presented in the same cycle as the load is decoded against the old values.
- R10: When near is greater than far, no request is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rng_we | input | 1 | Load strobe for the bus-number range |
| rng_near | input | 8 | New near (lowest downstream) bus number |
| rng_far | input | 8 | New far (highest downstream) bus number |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Configuration address of the request |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| out_valid | output | 1 | Registered request strobe |
| out_write | output | 1 | Registered write flag |
| out_claim | output | 1 | Request claimed by this bridge |
| out_conv | output | 1 | Request rewritten as a local cycle |
| out_addr | output | 32 | Forwarded or rewritten address |
| out_sel | output | 32 | One-hot device select on conversion |

## Verification
The assertions assume that reset stays low for a whole cycle and is not raised again while a request is in flight. They relate each output to the request one edge earlier and have no view of the range registers. The stimulus respects this by releasing reset once at the start. It keeps the bus field and both bounds in a small window of values so that equality with near, the edges of the range, inverted ranges and the all-zero range come up often. It also mixes all four type codes with idle cycles.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    // Field positions inside a routed configuration address
    localparam int TYPE_LSB = 0;
    localparam int REG_LSB  = 2;
    localparam int FN_LSB   = 8;
    localparam int DEV_LSB  = 11;
    localparam int BUS_LSB  = 16;

    typedef enum logic [1:0] {
        CT_LOCAL  = 2'b00,
        CT_ROUTED = 2'b01,
        CT_RSV2   = 2'b10,
        CT_RSV3   = 2'b11
    } ctype_e;

    typedef enum logic [1:0] {
        RT_DROP = 2'b00,
        RT_FWD  = 2'b01,
        RT_CONV = 2'b10
    } route_e;

endpackage

// File: rtl/cfgx_range_regs.sv
module cfgx_range_regs #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BUS_W-1:0] near_in,
    input  logic [BUS_W-1:0] far_in,
    output logic [BUS_W-1:0] near_q,
    output logic [BUS_W-1:0] far_q,
    output logic             armed
);

    typedef struct packed {
        logic [BUS_W-1:0] near;
        logic [BUS_W-1:0] far;
    } rng_t;

    rng_t rng_d, rng_q;

    always_comb begin
        rng_d = rng_q;
        if (we) begin
            rng_d.near = near_in;
            rng_d.far  = far_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rng_q <= '0;
        else        rng_q <= rng_d;
    end

    assign near_q = rng_q.near;
    assign far_q  = rng_q.far;
    // A zero far bound means no downstream bus has been assigned yet
    assign armed  = (rng_q.far != '0);

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  near,
    input  logic [BUS_W-1:0]  far,
    input  logic              armed,
    output route_e            route,
    output logic [DEV_W-1:0]  dev,
    output logic [ADDR_W-1:0] local_addr
);

    localparam int KEEP_W = DEV_LSB - REG_LSB;

    logic [BUS_W-1:0] bus;
    ctype_e           ctype;
    logic             above_near;
    logic             below_far;
    logic             hits_near;

    assign bus        = addr[BUS_LSB +: BUS_W];
    assign dev        = addr[DEV_LSB +: DEV_W];
    assign ctype      = ctype_e'(addr[TYPE_LSB +: 2]);
    assign above_near = (bus >= near);
    assign below_far  = (bus <= far);
    assign hits_near  = (bus == near);

    always_comb begin
        route = RT_DROP;
        if (ctype == CT_ROUTED && armed && above_near && below_far) begin
            route = hits_near ? RT_CONV : RT_FWD;
        end
    end

    // Local cycle: keep function and register, clear type and upper bits
    always_comb begin
        local_addr = '0;
        local_addr[REG_LSB +: KEEP_W] = addr[REG_LSB +: KEEP_W];
    end

endmodule

// File: rtl/cfgx_sel_dec.sv
module cfgx_sel_dec #(
    parameter int DEV_W   = 5,
    parameter int NUM_DEV = 1 << DEV_W
) (
    input  logic               en,
    input  logic [DEV_W-1:0]   dev,
    output logic [NUM_DEV-1:0] sel
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_line
        assign sel[g] = en && (dev == DEV_W'(g));
    end

endmodule

// File: rtl/cfgx_router.sv
module cfgx_router
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rng_we,
    input  logic [BUS_W-1:0]        rng_near,
    input  logic [BUS_W-1:0]        rng_far,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    output logic                    out_valid,
    output logic                    out_write,
    output logic                    out_claim,
    output logic                    out_conv,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [(1 << DEV_W)-1:0] out_sel
);

    localparam int NUM_DEV = 1 << DEV_W;

    typedef struct packed {
        logic               vld;
        logic               wr;
        logic               claim;
        logic               conv;
        logic [ADDR_W-1:0]  addr;
        logic [NUM_DEV-1:0] sel;
    } out_t;

    logic [BUS_W-1:0]   near_q;
    logic [BUS_W-1:0]   far_q;
    logic               armed;
    route_e             route;
    logic [DEV_W-1:0]   dev;
    logic [ADDR_W-1:0]  local_addr;
    logic               sel_en;
    logic [NUM_DEV-1:0] sel_vec;
    out_t               out_d, out_q;

    cfgx_range_regs #(.BUS_W(BUS_W)) u_range (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rng_we),
        .near_in (rng_near),
        .far_in  (rng_far),
        .near_q  (near_q),
        .far_q   (far_q),
        .armed   (armed)
    );

    cfgx_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEV_W(DEV_W)) u_decode (
        .addr       (req_addr),
        .near       (near_q),
        .far        (far_q),
        .armed      (armed),
        .route      (route),
        .dev        (dev),
        .local_addr (local_addr)
    );

    assign sel_en = req_valid && (route == RT_CONV);

    cfgx_sel_dec #(.DEV_W(DEV_W), .NUM_DEV(NUM_DEV)) u_sel (
        .en  (sel_en),
        .dev (dev),
        .sel (sel_vec)
    );

    always_comb begin
        out_d     = '0;
        out_d.vld = req_valid;
        if (req_valid) begin
            out_d.wr = req_write;
            unique case (route)
                RT_FWD: begin
                    out_d.claim = 1'b1;
                    out_d.addr  = req_addr;
                end
                RT_CONV: begin
                    out_d.claim = 1'b1;
                    out_d.conv  = 1'b1;
                    out_d.addr  = local_addr;
                    out_d.sel   = sel_vec;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_write = out_q.wr;
    assign out_claim = out_q.claim;
    assign out_conv  = out_q.conv;
    assign out_addr  = out_q.addr;
    assign out_sel   = out_q.sel;

endmodule

// File: rtl/cfgx_router_chk.sv
module cfgx_router_chk #(
    parameter int ADDR_W  = 32,
    parameter int NUM_DEV = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_write,
    input logic               out_valid,
    input logic               out_write,
    input logic               out_claim,
    input logic               out_conv,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [NUM_DEV-1:0] out_sel
);

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);  // R1
    AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_claim && out_sel == '0));  // R1
    AST_WRITE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_write == $past(req_write)));  // R1
    AST_TYPE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b01) |=> !out_claim);  // R2
    AST_CONV_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_conv |-> (out_claim && out_addr[1:0] == 2'b00));  // R4
    AST_CONV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_conv |-> (out_addr[10:2] == $past(req_addr[10:2])));  // R4
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_conv |-> ($countones(out_sel) == 1));  // R5
    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_conv |-> (out_sel == '0));  // R5
    AST_FWD_INTACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_claim && !out_conv) |-> (out_addr == $past(req_addr)));  // R6
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_claim |-> (!out_conv && out_addr == '0));  // R7

endmodule

bind cfgx_router cfgx_router_chk #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .out_valid (out_valid),
    .out_write (out_write),
    .out_claim (out_claim),
    .out_conv  (out_conv),
    .out_addr  (out_addr),
    .out_sel   (out_sel)
);

// File: tb/cfgx_router_bench.sv
module cfgx_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rng_we = 1'b0;
    logic [7:0]  rng_near = '0;
    logic [7:0]  rng_far = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        out_valid, out_write, out_claim, out_conv;
    logic [31:0] out_addr, out_sel;

    int checks = 0;
    int fails = 0;
    logic [7:0] m_near = '0;
    logic [7:0] m_far = '0;
    bit done = 0;

    typedef struct packed {
        logic        vld;
        logic        wr;
        logic        claim;
        logic        conv;
        logic [31:0] addr;
        logic [31:0] sel;
    } exp_t;

    always #5 clk = ~clk;

    cfgx_router u_cfgx_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .rng_we    (rng_we),
        .rng_near  (rng_near),
        .rng_far   (rng_far),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .out_valid (out_valid),
        .out_write (out_write),
        .out_claim (out_claim),
        .out_conv  (out_conv),
        .out_addr  (out_addr),
        .out_sel   (out_sel)
    );

    function automatic exp_t predict(logic v, logic [31:0] a, logic w,
                                     logic [7:0] nr, logic [7:0] fr);
        exp_t e = '0;
        logic [7:0] bus = a[23:16];
        e.vld = v;
        if (!v) return e;
        e.wr = w;
        if (a[1:0] == 2'b01 && fr != 0 && bus >= nr && bus <= fr) begin
            e.claim = 1'b1;
            if (bus == nr) begin
                e.conv = 1'b1;
                e.addr = {21'd0, a[10:2], 2'b00};
                e.sel  = 32'd1 << a[15:11];
            end else begin
                e.addr = a;
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] mk(logic [7:0] bus, logic [4:0] dev,
                                       logic [2:0] fn, logic [5:0] rg, logic [1:0] t);
        return {8'h00, bus, dev, fn, rg, t};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; compares one cycle later at the next falling edge
    task automatic step(logic v, logic [31:0] a, logic w, logic we,
                        logic [7:0] nr, logic [7:0] fr, string tag);
        exp_t e;
        req_valid = v; req_addr = a; req_write = w;
        rng_we = we; rng_near = nr; rng_far = fr;
        e = predict(v, a, w, m_near, m_far);
        if (we) begin m_near = nr; m_far = fr; end
        @(negedge clk);
        chk({tag, " R1 valid"}, {31'd0, out_valid}, {31'd0, e.vld});
        chk({tag, " R1 write"}, {31'd0, out_write}, {31'd0, e.wr});
        chk({tag, " R3 claim"}, {31'd0, out_claim}, {31'd0, e.claim});
        chk({tag, " R4 conv"},  {31'd0, out_conv},  {31'd0, e.conv});
        chk({tag, " R6 addr"},  out_addr, e.addr);
        chk({tag, " R5 sel"},   out_sel,  e.sel);
    endtask

    task automatic req(logic [31:0] a, logic w, string tag);
        step(1'b1, a, w, 1'b0, 8'd0, 8'd0, tag);
    endtask

    task automatic load(logic [7:0] nr, logic [7:0] fr);
        step(1'b0, 32'd0, 1'b0, 1'b1, nr, fr, "load R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [1:0]  t;
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R8 reset claim", {31'd0, out_claim}, 32'd0);
        chk("R8 reset addr", out_addr, 32'd0);
        chk("R8 reset sel", out_sel, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: unprogrammed range claims nothing, even bus 0
        req(mk(8'd0, 5'd2, 3'd0, 6'd1, 2'b01), 1'b0, "R8 bus0 unarmed");
        req(mk(8'd5, 5'd2, 3'd0, 6'd1, 2'b01), 1'b1, "R8 bus5 unarmed");

        // R9: load alongside a request; request sees the old (zero) range
        step(1'b1, mk(8'd3, 5'd2, 3'd1, 6'd9, 2'b01), 1'b0, 1'b1, 8'd3, 8'd7, "R9 same cycle");
        req(mk(8'd3, 5'd2, 3'd1, 6'd9, 2'b01), 1'b0, "R4 convert near");
        req(mk(8'd3, 5'd0, 3'd7, 6'd63, 2'b01), 1'b1, "R5 device 0");
        req(mk(8'd3, 5'd31, 3'd5, 6'd0, 2'b01), 1'b0, "R5 device 31");
        req({8'hA5, 8'd3, 5'd4, 3'd2, 6'd3, 2'b01}, 1'b0, "R4 upper bits cleared");
        req(mk(8'd4, 5'd6, 3'd3, 6'd2, 2'b01), 1'b1, "R6 forward inner");
        req(mk(8'd7, 5'd6, 3'd3, 6'd2, 2'b01), 1'b0, "R6 forward far edge");
        req(mk(8'd8, 5'd6, 3'd3, 6'd2, 2'b01), 1'b0, "R3 above far");
        req(mk(8'd2, 5'd6, 3'd3, 6'd2, 2'b01), 1'b0, "R3 below near");
        req(mk(8'd3, 5'd6, 3'd3, 6'd2, 2'b00), 1'b0, "R2 type 00");
        req(mk(8'd3, 5'd6, 3'd3, 6'd2, 2'b10), 1'b0, "R2 type 10");
        req(mk(8'd5, 5'd6, 3'd3, 6'd2, 2'b11), 1'b0, "R2 type 11");
        step(1'b0, mk(8'd3, 5'd6, 3'd3, 6'd2, 2'b01), 1'b1, 1'b0, 8'd0, 8'd0, "R1 idle");
        req(mk(8'd9, 5'd6, 3'd3, 6'd2, 2'b01), 1'b0, "R7 dropped");

        // R10: inverted range
        load(8'd9, 8'd4);
        req(mk(8'd9, 5'd1, 3'd0, 6'd0, 2'b01), 1'b0, "R10 bus near");
        req(mk(8'd4, 5'd1, 3'd0, 6'd0, 2'b01), 1'b0, "R10 bus far");
        req(mk(8'd6, 5'd1, 3'd0, 6'd0, 2'b01), 1'b0, "R10 bus between");

        // near 0 with a nonzero far bound is armed
        load(8'd0, 8'd5);
        req(mk(8'd0, 5'd17, 3'd4, 6'd12, 2'b01), 1'b1, "R4 near zero");

        // back to unarmed
        load(8'd0, 8'd0);
        req(mk(8'd0, 5'd17, 3'd4, 6'd12, 2'b01), 1'b1, "R8 disarmed again");

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic v, w, we;
            logic [7:0] nr, fr;
            v  = ($urandom_range(99) < 85);
            w  = $urandom_range(1);
            we = ($urandom_range(99) < 8);
            nr = 8'($urandom_range(12));
            fr = 8'($urandom_range(12));
            t  = ($urandom_range(99) < 70) ? 2'b01 : 2'($urandom_range(3));
            a  = $urandom;
            a[23:16] = 8'($urandom_range(13));
            a[1:0]   = t;
            step(v, a, w, we, nr, fr, "rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule